// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer with Address-Space Tags

This block turns a 32-bit virtual address into a physical address for a load or store. The top three address bits select a segment. Two kernel segments bypass translation and map straight onto the low physical space, one cacheable and one not. The user segment and the upper kernel segment are translated. For a translated access, all 64 entries are compared against the virtual page number and the current address-space tag in the same cycle. Because every entry carries its own address-space tag, translations from different processes can stay resident across a context switch, and the buffer does not have to be flushed.

Each lookup is presented for one cycle and returns a registered response on the next cycle. The response is exactly one of three outcomes:
- **Success:** a physical address, with a cacheability flag.
- **Miss:** the translation is absent. Refill is left to a software handler, which loads an entry through the indexed write port.
- **Protection fault:** the access is not allowed.

On a successful translation, the entry's referenced bit is set. A store also sets the entry's dirty bit. The response reports the values these bits held before the access.

A single-cycle invalidate input drops every entry at once. If more than one entry matches, the lookup still succeeds using the lowest-numbered match, and an error flag is raised alongside it.

Top module: `tlb_xlate`

## Requirements
- R1: The buffer holds 64 entries. An entry at any index is found by a lookup whose address bits [31:12] equal the entry's page number, whose address-space tag equals the entry's tag, and while the entry is valid.
- R2: A translated success returns `rsp_pa` = {entry frame, lookup address bits [11:0]}. The page offset is passed through unchanged.
- R3: An entry whose address-space tag differs from `cur_asid` never matches, even when its page number is equal.
- R4: Address bits [31:29] select the segment, as follows. Whenever `rsp_ok` is 0, `rsp_cached` is 0.

  | Bits [31:29] | Segment | Translated | `rsp_pa` on success | `rsp_cached` |
  |---|---|---|---|---|
  | 100 | Kernel direct | No | {000, address bits [28:0]} | 1 |
  | 101 | Kernel direct | No | {000, address bits [28:0]} | 0 |
  | 0xx | User | Yes | See R2 | Entry's cacheable bit |
  | 11x | Kernel mapped | Yes | See R2 | Entry's cacheable bit |

- R5: When a translated access finds no matching entry, the response has `rsp_miss`=1, `rsp_ok`=0 and `rsp_pa`=0, and no entry changes.
- R6: `rsp_prot`=1 and `rsp_ok`=0 in either of these cases:
  - the access is a store (`lk_write`=1) that matches an entry whose writable bit is 0;
  - the access is made in user mode (`lk_kernel`=0) with address bit 31 set.
- R7: A translated success sets the selected entry's referenced bit. If the access is a store, it also sets the entry's dirty bit. `rsp_dirty` and `rsp_ref` report the bits as they were before the access. For direct-segment accesses, both are 0.
- R8: A software write (`wr_en`) loads the indexed entry and clears its dirty and referenced bits. The new entry is seen by lookups presented from the next cycle onward; a lookup in the same cycle sees the old contents. When a write and a status update target the same index in the same cycle, the write wins.
- R9: `inv_all` clears every valid bit in one cycle, taking precedence over a write in the same cycle.
- R10: When several entries match, the lowest-index match is used and `rsp_multi`=1.
- R11: The response is registered: `rsp_valid` equals `lk_valid` delayed by one cycle. When `rsp_valid` is 1, exactly one of `rsp_ok`, `rsp_miss` and `rsp_prot` is 1. When `rsp_valid` is 0, all response outputs are 0.
- R12: After reset, all entries are invalid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_write | input | 1 | Lookup is a store |
| lk_kernel | input | 1 | Access made in kernel mode |
| cur_asid | input | 6 | Current address-space tag |
| wr_en | input | 1 | Software entry write |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 6 | Address-space tag to store |
| wr_pfn | input | 20 | Physical frame to store |
| wr_rw | input | 1 | Entry writable (0 = read only) |
| wr_cc | input | 1 | Entry cacheable |
| wr_vld | input | 1 | Entry valid |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_prot | output | 1 | Protection fault |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | 32 | Physical address |
| rsp_cached | output | 1 | Access is cacheable |
| rsp_dirty | output | 1 | Entry dirty bit before access |
| rsp_ref | output | 1 | Entry referenced bit before access |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions:
- a lookup that hits an entry while software overwrites that same index;
- an invalidate that lands together with a write.

Only in these cases do the lookup-sees-old-state rule and the write-over-status and invalidate-over-write precedences become visible. The bench drives these collisions as directed cycles. A random phase then draws page numbers from a small pool, so duplicate entries, tag mismatches and read-only stores occur often. Throughout, a behavioural model predicts every response field.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int SEG_W = 3;

  typedef enum logic [1:0] {
    SEG_USER,
    SEG_KDIRECT_C,
    SEG_KDIRECT_U,
    SEG_KMAPPED
  } seg_e;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [SEG_W-1:0] top_bits,
  output seg_e             seg
);
  always_comb begin
    unique casez (top_bits)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KDIRECT_C;
      3'b101:  seg = SEG_KDIRECT_U;
      default: seg = SEG_KMAPPED;
    endcase
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [IDX_W-1:0]   hit_idx
);
  assign any_hit   = |match_vec;
  assign multi_hit = |(match_vec & (match_vec - ENTRIES'(1)));

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_rw,
  input  logic               wr_cc,
  input  logic               wr_vld,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_dirty,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [PFN_W-1:0]   sel_pfn,
  output logic               sel_rw,
  output logic               sel_cc,
  output logic               sel_dirty,
  output logic               sel_ref
);
  logic [ENTRIES*PFN_W-1:0] pfn_all;
  logic [ENTRIES-1:0]       rw_all, cc_all, dty_all, ref_all;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              vld_q, vld_d, dty_q, dty_d, ref_q, ref_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              rw_q, cc_q;
    logic              wr_this, up_this;

    assign wr_this = wr_en  && (wr_idx  == IDX_W'(g));
    assign up_this = upd_en && (upd_idx == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      dty_d = dty_q;
      ref_d = ref_q;
      if (up_this) begin
        ref_d = 1'b1;
        if (upd_dirty) dty_d = 1'b1;
      end
      if (wr_this) begin
        vld_d = wr_vld;
        dty_d = 1'b0;
        ref_d = 1'b0;
      end
      if (inv_all) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dty_q <= 1'b0;
        ref_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        dty_q <= dty_d;
        ref_q <= ref_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_this) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        pfn_q  <= wr_pfn;
        rw_q   <= wr_rw;
        cc_q   <= wr_cc;
      end
    end

    assign match_vec[g] = vld_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    assign pfn_all[g*PFN_W +: PFN_W] = pfn_q;
    assign rw_all[g]  = rw_q;
    assign cc_all[g]  = cc_q;
    assign dty_all[g] = dty_q;
    assign ref_all[g] = ref_q;
  end

  assign sel_pfn   = pfn_all[sel_idx*PFN_W +: PFN_W];
  assign sel_rw    = rw_all[sel_idx];
  assign sel_cc    = cc_all[sel_idx];
  assign sel_dirty = dty_all[sel_idx];
  assign sel_ref   = ref_all[sel_idx];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_write,
  input  logic              lk_kernel,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_rw,
  input  logic              wr_cc,
  input  logic              wr_vld,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_miss,
  output logic              rsp_prot,
  output logic              rsp_multi,
  output logic [VA_W-1:0]   rsp_pa,
  output logic              rsp_cached,
  output logic              rsp_dirty,
  output logic              rsp_ref
);
  logic               rst_s_n;
  seg_e               seg;
  logic [ENTRIES-1:0] match_vec;
  logic               any_hit, multi_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   sel_pfn;
  logic               sel_rw, sel_cc, sel_dirty, sel_ref;
  logic               mapped, mode_viol, store_viol, xl_ok, upd_en;

  logic              valid_d, ok_d, miss_d, prot_d, multi_d, cached_d, dirty_d, ref_d;
  logic [VA_W-1:0]   pa_d;

  tlb_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  tlb_seg_decode i_seg (.top_bits(lk_va[VA_W-1 -: SEG_W]), .seg(seg));

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) i_store (
    .clk(clk), .rst_n(rst_s_n), .inv_all(inv_all),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .wr_rw(wr_rw), .wr_cc(wr_cc), .wr_vld(wr_vld),
    .upd_en(upd_en), .upd_idx(hit_idx), .upd_dirty(lk_write),
    .lk_vpn(lk_va[VA_W-1:OFF_W]), .lk_asid(cur_asid), .sel_idx(hit_idx),
    .match_vec(match_vec), .sel_pfn(sel_pfn), .sel_rw(sel_rw), .sel_cc(sel_cc),
    .sel_dirty(sel_dirty), .sel_ref(sel_ref)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) i_pick (
    .match_vec(match_vec), .any_hit(any_hit), .multi_hit(multi_hit), .hit_idx(hit_idx)
  );

  assign mapped     = (seg == SEG_USER) || (seg == SEG_KMAPPED);
  assign mode_viol  = !lk_kernel && lk_va[VA_W-1];
  assign store_viol = mapped && any_hit && lk_write && !sel_rw;
  assign xl_ok      = lk_valid && !mode_viol && (!mapped || (any_hit && !store_viol));
  assign upd_en     = xl_ok && mapped;

  always_comb begin
    valid_d  = lk_valid;
    ok_d     = xl_ok;
    miss_d   = lk_valid && !mode_viol && mapped && !any_hit;
    prot_d   = lk_valid && (mode_viol || store_viol);
    multi_d  = lk_valid && !mode_viol && mapped && multi_hit;
    pa_d     = '0;
    cached_d = 1'b0;
    dirty_d  = 1'b0;
    ref_d    = 1'b0;
    if (xl_ok) begin
      if (mapped) begin
        pa_d     = {sel_pfn, lk_va[OFF_W-1:0]};
        cached_d = sel_cc;
        dirty_d  = sel_dirty;
        ref_d    = sel_ref;
      end else begin
        pa_d     = {{SEG_W{1'b0}}, lk_va[VA_W-SEG_W-1:0]};
        cached_d = (seg == SEG_KDIRECT_C);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_prot   <= 1'b0;
      rsp_multi  <= 1'b0;
      rsp_pa     <= '0;
      rsp_cached <= 1'b0;
      rsp_dirty  <= 1'b0;
      rsp_ref    <= 1'b0;
    end else begin
      rsp_valid  <= valid_d;
      rsp_ok     <= ok_d;
      rsp_miss   <= miss_d;
      rsp_prot   <= prot_d;
      rsp_multi  <= multi_d;
      rsp_pa     <= pa_d;
      rsp_cached <= cached_d;
      rsp_dirty  <= dirty_d;
      rsp_ref    <= ref_d;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_kernel,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic            rsp_miss,
  input logic            rsp_prot,
  input logic            rsp_multi,
  input logic [VA_W-1:0] rsp_pa,
  input logic            rsp_cached
);
  // R11
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R11
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_ok && !rsp_miss && !rsp_prot && !rsp_multi && rsp_pa == '0));
  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_prot}) == 1));
  // R6
  user_kseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_kernel && lk_va[VA_W-1]) |=> rsp_prot);
  // R4
  direct_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kernel && lk_va[VA_W-1 -: 2] == 2'b10) |=>
      (rsp_ok && rsp_pa == {3'b000, $past(lk_va[VA_W-4:0])} && rsp_cached == !$past(lk_va[VA_W-3])));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));
  // R10
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_ok || rsp_prot));
  // R4
  cached_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cached |-> rsp_ok);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_kernel(lk_kernel),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
  .rsp_multi(rsp_multi), .rsp_pa(rsp_pa), .rsp_cached(rsp_cached)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  localparam int N = 64;

  logic        clk, rst_n;
  logic        lk_valid, lk_write, lk_kernel;
  logic [31:0] lk_va;
  logic [5:0]  cur_asid;
  logic        wr_en, wr_rw, wr_cc, wr_vld, inv_all;
  logic [5:0]  wr_idx, wr_asid;
  logic [19:0] wr_vpn, wr_pfn;
  logic        rsp_valid, rsp_ok, rsp_miss, rsp_prot, rsp_multi, rsp_cached, rsp_dirty, rsp_ref;
  logic [31:0] rsp_pa;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .lk_kernel(lk_kernel), .cur_asid(cur_asid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_rw(wr_rw), .wr_cc(wr_cc),
    .wr_vld(wr_vld), .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
    .rsp_cached(rsp_cached), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit timed_out = 0;

  // behavioural reference state
  bit        m_vld[N], m_rw[N], m_cc[N], m_d[N], m_r[N];
  bit [19:0] m_vpn[N], m_pfn[N];
  bit [5:0]  m_asid[N];
  bit        e_valid, e_ok, e_miss, e_prot, e_multi, e_cached, e_d, e_r;
  bit [31:0] e_pa;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_va = '0; lk_write = 0; lk_kernel = 0; cur_asid = '0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_pfn = '0;
    wr_rw = 0; wr_cc = 0; wr_vld = 0; inv_all = 0;
  endtask

  task automatic tick();
    int hit = -1;
    int cnt = 0;
    int first = -1;
    e_valid = lk_valid; e_ok = 0; e_miss = 0; e_prot = 0; e_multi = 0;
    e_cached = 0; e_d = 0; e_r = 0; e_pa = '0;
    if (lk_valid) begin
      if (!lk_kernel && lk_va[31]) e_prot = 1;
      else if (lk_va[31:30] == 2'b10) begin
        e_ok = 1; e_pa = {3'b000, lk_va[28:0]}; e_cached = !lk_va[29];
      end else begin
        for (int i = 0; i < N; i++)
          if (m_vld[i] && m_vpn[i] == lk_va[31:12] && m_asid[i] == cur_asid) begin
            cnt++;
            if (first < 0) first = i;
          end
        if (cnt == 0) e_miss = 1;
        else begin
          e_multi = (cnt > 1);
          if (lk_write && !m_rw[first]) e_prot = 1;
          else begin
            e_ok = 1; hit = first; e_pa = {m_pfn[first], lk_va[11:0]};
            e_cached = m_cc[first]; e_d = m_d[first]; e_r = m_r[first];
          end
        end
      end
    end
    @(posedge clk);
    if (hit >= 0) begin
      m_r[hit] = 1;
      if (lk_write) m_d[hit] = 1;
    end
    if (wr_en) begin
      m_vld[wr_idx] = wr_vld; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
      m_pfn[wr_idx] = wr_pfn; m_rw[wr_idx] = wr_rw; m_cc[wr_idx] = wr_cc;
      m_d[wr_idx] = 0; m_r[wr_idx] = 0;
    end
    if (inv_all) for (int i = 0; i < N; i++) m_vld[i] = 0;
    @(negedge clk);
    chk("R11 valid", rsp_valid, e_valid);
    chk("R1 ok", rsp_ok, e_ok);
    chk("R5 miss", rsp_miss, e_miss);
    chk("R6 prot", rsp_prot, e_prot);
    chk("R10 multi", rsp_multi, e_multi);
    chk("R2 pa", rsp_pa, e_pa);
    chk("R4 cached", rsp_cached, e_cached);
    chk("R7 dirty", rsp_dirty, e_d);
    chk("R7 ref", rsp_ref, e_r);
  endtask

  task automatic do_wr(input int idx, input bit [19:0] vpn, input bit [5:0] asid,
                       input bit [19:0] pfn, input bit rw, input bit cc);
    idle();
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
    wr_rw = rw; wr_cc = cc; wr_vld = 1;
    tick();
    idle();
  endtask

  task automatic do_lk(input bit [31:0] va, input bit wr, input bit kern, input bit [5:0] asid);
    idle();
    lk_valid = 1; lk_va = va; lk_write = wr; lk_kernel = kern; cur_asid = asid;
    tick();
    idle();
  endtask

  task automatic run();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    chk("R12 reset valid", rsp_valid, 0);
    chk("R12 reset pa", rsp_pa, 0);
    rst_n = 1;
    repeat (3) tick();
    // R12: no entry valid after reset
    do_lk(32'h0040_0ABC, 0, 0, 6'd3);
    chk("R12 empty miss", rsp_miss, 1);

    // R1 R2: basic translation at index 5
    do_wr(5, 20'h00400, 6'd3, 20'h12345, 1, 1);
    do_lk(32'h0040_0ABC, 0, 0, 6'd3);
    chk("R2 pa", rsp_pa, 32'h1234_5ABC);
    chk("R1 ok", rsp_ok, 1);
    chk("R7 ref before", rsp_ref, 0);
    // R3: other tag misses
    do_lk(32'h0040_0ABC, 0, 0, 6'd4);
    chk("R3 miss", rsp_miss, 1);
    // R7: store sets dirty, reported next time
    do_lk(32'h0040_0010, 1, 0, 6'd3);
    chk("R7 ref seen", rsp_ref, 1);
    chk("R7 dirty old", rsp_dirty, 0);
    do_lk(32'h0040_0010, 0, 0, 6'd3);
    chk("R7 dirty set", rsp_dirty, 1);

    // R6: read-only entry at 63
    do_wr(63, 20'h7FFFF, 6'd3, 20'h0ABCD, 0, 0);
    do_lk(32'h7FFF_F004, 1, 0, 6'd3);
    chk("R6 store ro", rsp_prot, 1);
    do_lk(32'h7FFF_F004, 0, 0, 6'd3);
    chk("R4 uncached entry", rsp_cached, 0);
    chk("R1 idx63 pa", rsp_pa, 32'h0ABC_D004);

    // R4 R6: segments
    do_lk(32'h8000_1234, 0, 0, 6'd3);
    chk("R6 user kseg", rsp_prot, 1);
    do_lk(32'h8000_1234, 0, 1, 6'd3);
    chk("R4 kdirect cached pa", rsp_pa, 32'h0000_1234);
    chk("R4 kdirect cached", rsp_cached, 1);
    do_lk(32'hA123_4567, 1, 1, 6'd3);
    chk("R4 kdirect uncached pa", rsp_pa, 32'h0123_4567);
    chk("R4 kdirect uncached", rsp_cached, 0);
    do_wr(0, 20'hC0000, 6'd3, 20'h00777, 1, 1);
    do_lk(32'hC000_0008, 0, 1, 6'd3);
    chk("R4 kmapped", rsp_pa, 32'h0077_7008);
    do_lk(32'hC000_0008, 0, 0, 6'd3);
    chk("R6 user kmapped", rsp_prot, 1);

    // R10: duplicates at 10 and 20
    do_wr(20, 20'h00123, 6'd1, 20'h00BBB, 1, 0);
    do_wr(10, 20'h00123, 6'd1, 20'h00AAA, 1, 0);
    do_lk(32'h0012_3FFF, 0, 0, 6'd1);
    chk("R10 lowest", rsp_pa, 32'h00AA_AFFF);
    chk("R10 multi", rsp_multi, 1);

    // R8: write colliding with lookup of same index
    idle();
    lk_valid = 1; lk_va = 32'h0055_5000; cur_asid = 6'd2;
    wr_en = 1; wr_idx = 6'd7; wr_vpn = 20'h00555; wr_asid = 6'd2; wr_pfn = 20'h00321;
    wr_rw = 1; wr_cc = 1; wr_vld = 1;
    tick();
    chk("R8 same-cycle old", rsp_miss, 1);
    do_lk(32'h0055_5000, 1, 0, 6'd2);
    chk("R8 visible next", rsp_pa, 32'h0032_1000);
    // R8: status update and rewrite collide; write wins
    idle();
    lk_valid = 1; lk_va = 32'h0055_5000; lk_write = 1; cur_asid = 6'd2;
    wr_en = 1; wr_idx = 6'd7; wr_vpn = 20'h00555; wr_asid = 6'd2; wr_pfn = 20'h00321;
    wr_rw = 1; wr_cc = 1; wr_vld = 1;
    tick();
    do_lk(32'h0055_5000, 0, 0, 6'd2);
    chk("R8 write beats status", rsp_dirty, 0);

    // R11: idle cycle quiet
    idle();
    tick();
    chk("R11 idle", {rsp_valid, rsp_ok, rsp_miss, rsp_prot}, 0);

    // R9: invalidate together with write
    idle();
    inv_all = 1; wr_en = 1; wr_idx = 6'd30; wr_vpn = 20'h00999; wr_asid = 6'd0;
    wr_pfn = 20'h1; wr_rw = 1; wr_vld = 1;
    tick();
    do_lk(32'h0099_9000, 0, 0, 6'd0);
    chk("R9 write dropped", rsp_miss, 1);
    do_lk(32'h0040_0ABC, 0, 0, 6'd3);
    chk("R9 old gone", rsp_miss, 1);

    // random phase: small pools for collisions
    for (int c = 0; c < 3000; c++) begin
      bit [19:0] pool[4] = '{20'h00010, 20'h00011, 20'hC0010, 20'h7FFF0};
      idle();
      if ($urandom_range(0, 7) == 0) begin
        wr_en = 1; wr_idx = 6'($urandom_range(0, 63)); wr_vpn = pool[$urandom_range(0, 3)];
        wr_asid = 6'($urandom_range(0, 3)); wr_pfn = 20'($urandom);
        wr_rw = 1'($urandom); wr_cc = 1'($urandom); wr_vld = ($urandom_range(0, 7) != 0);
      end
      if ($urandom_range(0, 255) == 0) inv_all = 1;
      if ($urandom_range(0, 3) != 0) begin
        lk_valid = 1; lk_write = 1'($urandom); lk_kernel = 1'($urandom);
        cur_asid = 6'($urandom_range(0, 3));
        if ($urandom_range(0, 5) == 0) lk_va = {($urandom_range(0, 1) ? 3'b100 : 3'b101), 29'($urandom)};
        else lk_va = {pool[$urandom_range(0, 3)], 12'($urandom)};
      end
      tick();
    end
  endtask

  initial begin
    fork
      run();
      begin repeat (60000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule